// File: doc/BRIEF.md
# Serial ADC Output Shift Logic

This block is a behavioural stand-in for the digital output side of a 14-bit sampling converter. A falling edge on the active-low conversion-start input begins a conversion. The block raises a busy flag for a fixed number of system clock cycles. When busy drops, the block captures the 14-bit parallel result, pads it with two leading zeros to a 16-bit word, and makes that word ready to be read.

An external master supplies the serial clock, and the block is always the slave. The block sends one bit per rising edge of the serial clock, most significant bit first, so the master can sample on the falling edge. The serial clock may stop and restart at any time, so the word can be read in several bytes. A bit-position counter keeps the reads aligned with conversions. That counter returns to the first bit when conversion-start falls while the serial clock is low. Both asynchronous inputs are brought into the system clock domain through flop synchronizers, and their edges are detected there.

Top module: `serial_adc_tx`

## Requirements
- R1: After reset, busy_o and sdata_o are both 0.
- R2: A falling edge on conv_start_n_i, seen while idle, sets busy_o high for exactly CONV_CYCLES consecutive system clock cycles.
- R3: Falling edges on conv_start_n_i while busy_o is high are ignored and do not lengthen the conversion.
- R4: In the cycle busy_o falls, the output word is loaded as {2'b00, result_i}, using result_i as it stands in that cycle.
- R5: The word is sent most significant bit first. The n-th serial clock rising edge after a load (n = 1..16) drives word bit 16-n on sdata_o, so the first two bits are zero.
- R6: Every serial clock rising edge after the 16th drives 0 on sdata_o.
- R7: The bit position is held while the serial clock is idle, so a word read in chunks with gaps between them equals one continuous read.
- R8: A falling edge on conv_start_n_i while sclk_i is low resets the bit position. The next rising edge then drives bit 15 of the word currently held.
- R9: A falling edge on conv_start_n_i while sclk_i is high leaves the bit position unchanged.
- R10: After a load, sdata_o is 0 until the first serial clock rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_start_n_i | input | 1 | Asynchronous conversion start; its falling edge is the event |
| sclk_i | input | 1 | Asynchronous serial clock from the master |
| result_i | input | RES_W | Parallel conversion result, captured when busy falls |
| busy_o | output | 1 | High while a conversion is in progress |
| sdata_o | output | 1 | Serial data; changes after each serial clock rising edge |

## Verification
The assertions check on every cycle the causes of the busy edges, the countdown being left alone by a second start, the range of the bit position, the clearing done by a load, the zero tail, and the reset-or-hold choice made when a start edge arrives. Only the bench scenarios can show the data itself. These scenarios cover the bit order of random results read in random chunks with random gaps, the exact busy length, and a replay of the held word after a realigning start during a conversion. They also show that a start arriving while the serial clock is high leaves a read in progress untouched.

// File: rtl/serial_adc_pkg.sv
// Shared constants for the serial converter output logic.
package serial_adc_pkg;
    // Number of zero bits placed ahead of the result in the serial word.
    localparam int PAD_W = 2;
endpackage

// File: rtl/adc_sync.sv
// Flop synchronizer for one asynchronous level.
// Assumes: raw_i may change at any time; STAGES >= 2.
// Gives the synchronized level and its value one cycle earlier, so the
// parent can form rising and falling edges.
module adc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic level_o,
    output logic prev_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Shift the raw input through the chain and keep one older copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
            prev_q  <= RST_VAL;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], raw_i};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign level_o = chain_q[STAGES-1];
    assign prev_o  = prev_q;
endmodule

// File: rtl/adc_conv_timer.sv
// Conversion timer: a start pulse seen while idle raises busy for
// CONV_CYCLES cycles. done_o is high in the last busy cycle.
// Assumes: start_i is a one-cycle pulse in the clk domain.
module adc_conv_timer #(
    parameter int CONV_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CNT_W = $clog2(CONV_CYCLES + 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;

    // Start the countdown when idle and count down to zero while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!busy_q) begin
            if (start_i) begin
                busy_q <= 1'b1;
                cnt_q  <= CNT_W'(CONV_CYCLES - 1);
            end
        end else if (cnt_q == '0) begin
            busy_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign busy_o = busy_q;
    assign done_o = busy_q && (cnt_q == '0);

    assert_busy_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> $past(start_i));
    assert_busy_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> $past(cnt_q) == '0);
    assert_no_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start_i && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/adc_out_shifter.sv
// Output word register and bit-position counter.
// Assumes: load_i, rise_i and realign_i are one-cycle pulses in the clk
// domain. rise_i and a realign with the serial clock low never coincide.
// Priority: load, then start edge, then serial clock rising edge.
module adc_out_shifter #(
    parameter int RES_W  = 14,
    parameter int WORD_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [RES_W-1:0] result_i,
    input  logic             rise_i,
    input  logic             start_i,
    input  logic             sclk_lvl_i,
    output logic             sdata_o
);
    localparam int POS_W = $clog2(WORD_W + 1);

    logic [WORD_W-1:0] word_q;
    logic [POS_W-1:0]  pos_q;
    logic              sdata_q;
    logic [POS_W-1:0]  idx;

    // Index of the word bit sent at the next rising edge.
    always_comb idx = POS_W'(WORD_W - 1) - pos_q;

    // Load a new word, realign, or send the next bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            pos_q   <= '0;
            sdata_q <= 1'b0;
        end else if (load_i) begin
            word_q  <= WORD_W'(result_i);
            pos_q   <= '0;
            sdata_q <= 1'b0;
        end else if (start_i && !sclk_lvl_i) begin
            pos_q   <= '0;
            sdata_q <= 1'b0;
        end else if (rise_i) begin
            if (pos_q < POS_W'(WORD_W)) begin
                sdata_q <= word_q[idx];
                pos_q   <= pos_q + POS_W'(1);
            end else begin
                sdata_q <= 1'b0;
            end
        end
    end

    assign sdata_o = sdata_q;

    assert_load_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (pos_q == '0 && !sdata_q));
    assert_pos_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= POS_W'(WORD_W));
    assert_tail_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i && !load_i && pos_q == POS_W'(WORD_W)) |=> !sdata_q);
    assert_realign_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !sclk_lvl_i && !load_i) |=> pos_q == '0);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && sclk_lvl_i && !load_i && !rise_i) |=> $stable(pos_q));
endmodule

// File: rtl/serial_adc_tx.sv
// Top of the serial converter output logic. It synchronizes the start
// and serial clock inputs, runs the conversion timer and drives the
// serial output word.
// Assumes: result_i is stable in the cycle busy_o falls.
module serial_adc_tx
    import serial_adc_pkg::*;
#(
    parameter int RES_W       = 14,
    parameter int CONV_CYCLES = 40,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_start_n_i,
    input  logic             sclk_i,
    input  logic [RES_W-1:0] result_i,
    output logic             busy_o,
    output logic             sdata_o
);
    localparam int WORD_W = RES_W + PAD_W;

    logic cs_lvl, cs_prev, sck_lvl, sck_prev;
    logic cs_fall, sck_rise, done;

    adc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
        .clk(clk), .rst_n(rst_n), .raw_i(conv_start_n_i),
        .level_o(cs_lvl), .prev_o(cs_prev));

    adc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
        .clk(clk), .rst_n(rst_n), .raw_i(sclk_i),
        .level_o(sck_lvl), .prev_o(sck_prev));

    // Edge events in the system clock domain.
    always_comb begin
        cs_fall  = cs_prev && !cs_lvl;
        sck_rise = !sck_prev && sck_lvl;
    end

    adc_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start_i(cs_fall),
        .busy_o(busy_o), .done_o(done));

    adc_out_shifter #(.RES_W(RES_W), .WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load_i(done), .result_i(result_i),
        .rise_i(sck_rise), .start_i(cs_fall), .sclk_lvl_i(sck_lvl),
        .sdata_o(sdata_o));

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !sdata_o));
endmodule

// File: tb/serial_adc_tx_bench.sv
module serial_adc_tx_bench;
    localparam int RES_W = 14;
    localparam int CONV  = 60;

    logic clk = 1'b0, rst_n = 1'b0, conv_n = 1'b1, sclk = 1'b0;
    logic [RES_W-1:0] result = '0;
    logic busy, sdata;
    int total = 0, bad = 0;

    always #4 clk = ~clk;

    serial_adc_tx #(.RES_W(RES_W), .CONV_CYCLES(CONV)) u_serial_adc_tx (
        .clk(clk), .rst_n(rst_n), .conv_start_n_i(conv_n), .sclk_i(sclk),
        .result_i(result), .busy_o(busy), .sdata_o(sdata));

    function automatic logic [15:0] exp_word(input logic [RES_W-1:0] r);
        return {2'b00, r};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse(output logic b);
        @(negedge clk) sclk = 1'b1;
        repeat (5) @(negedge clk);
        b = sdata;
        sclk = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    // Start a conversion, optionally with a second start edge mid-way, and measure busy length.
    task automatic convert(input bit glitch, output int len);
        int t = 0;
        bit seen = 0;
        len = 0;
        @(negedge clk) conv_n = 1'b0;
        while (t < 4 * CONV) begin
            @(negedge clk);
            t++;
            if (t == 6) conv_n = 1'b1;
            if (glitch && t == 20) conv_n = 1'b0;
            if (glitch && t == 26) conv_n = 1'b1;
            if (busy) begin seen = 1; len++; end
            else if (seen) break;
        end
        conv_n = 1'b1;
    endtask

    task automatic read_chunks(input int nbits, output logic [15:0] got);
        int done = 0;
        logic b;
        got = '0;
        while (done < nbits) begin
            int chunk = 1 + int'($urandom_range(7));
            for (int i = 0; i < chunk && done < nbits; i++) begin
                pulse(b);
                got = {got[14:0], b};
                done++;
            end
            repeat ($urandom_range(20)) @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int len;
        logic [15:0] got, wa, wb;
        logic b;
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !sdata, "R1 reset idle", {busy, sdata}, 0);

        // Random conversions read in random chunks.
        for (int k = 0; k < 16; k++) begin
            result = RES_W'($urandom);
            convert(1'b0, len);
            check(len == CONV, "R2 busy length", len, CONV);
            check(sdata == 1'b0, "R10 idle output after load", sdata, 0);
            read_chunks(16, got);
            check(got == exp_word(result), "R4 R5 R7 word", got, exp_word(result));
            if (k % 4 == 0) begin
                pulse(b);
                check(b == 1'b0, "R6 tail bit 17", b, 0);
                pulse(b);
                check(b == 1'b0, "R6 tail bit 18", b, 0);
            end
        end

        // Second start edge inside a conversion.
        result = 14'h3A5C;
        convert(1'b1, len);
        check(len == CONV, "R3 ignored restart length", len, CONV);
        read_chunks(16, got);
        check(got == exp_word(14'h3A5C), "R3 word after restart", got, exp_word(14'h3A5C));

        // Realign with serial clock low: replay of the held word during busy.
        result = 14'h2B6D;
        convert(1'b0, len);
        wa = exp_word(14'h2B6D);
        read_chunks(5, got);
        result = 14'h1F0E;
        @(negedge clk) conv_n = 1'b0;
        repeat (6) @(negedge clk);
        conv_n = 1'b1;
        got = '0;
        for (int i = 0; i < 3; i++) begin pulse(b); got = {got[14:0], b}; end
        check(busy == 1'b1, "R8 still busy", busy, 1);
        check(got[2:0] == wa[15:13], "R8 replay", got[2:0], wa[15:13]);
        while (busy) @(negedge clk);
        @(negedge clk);
        read_chunks(16, got);
        wb = exp_word(14'h1F0E);
        check(got == wb, "R8 next word", got, wb);

        // Start edge with serial clock high keeps position.
        result = 14'h0D33;
        convert(1'b0, len);
        wa = exp_word(14'h0D33);
        read_chunks(5, got);
        @(negedge clk) sclk = 1'b1;
        repeat (5) @(negedge clk);
        b = sdata;
        check(b == wa[10], "R9 bit before start", b, wa[10]);
        conv_n = 1'b0;
        repeat (6) @(negedge clk);
        conv_n = 1'b1;
        sclk = 1'b0;
        repeat (5) @(negedge clk);
        pulse(b);
        check(b == wa[9], "R9 position held", b, wa[9]);
        while (busy) @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule